// File: doc/BRIEF.md
# DDR Serial ADC Frame Deserializer

This block turns one serial data lane from a high-speed ADC into parallel samples. Each bit-clock period it receives two data bits that an input DDR register has already captured. The bit taken on the rising edge is the earlier of the two. It also receives the matching pair of frame-clock bits, captured the same way.

Incoming data bits pass through a shift register. The last frame-clock bit of each period is kept in a register. With that copy, the block finds the data bit on which the frame clock goes high, which is the first bit (MSB) of a sample. That bit can sit in either half of a bit-clock period. For this reason the block picks one of two 14-bit windows: one aligned to the pair, and one offset by a single bit. The chosen window is copied into the sample register once per frame, and a one-cycle valid strobe goes with it.

The block checks the spacing between frame starts. When two starts are not exactly one sample width apart, it raises a sticky misalignment flag. That flag stays set until it is cleared.

Top module: `ddrdes_top`

## Requirements
- R1: Serial bits are assembled MSB first, and in each pair the rising-edge bit comes before the falling-edge bit. A sample is the 14 consecutive data bits that begin at the bit where the frame bit stream changes from 0 to 1.
- R2: When the frame start falls on the rising-edge bit of a pair, a repeated pattern such as 11111110000000 comes out exactly as sent, with no rotation.
- R3: When the frame start falls on the falling-edge bit of a pair, samples still come out exactly as sent, with no rotation.
- R4: Each sample is delivered by a `sample_valid_o` pulse that lasts one cycle. The pulse is seen after the rising clock edge that took in the pair holding the frame start that follows the sample. Two pulses are never in consecutive cycles.
- R5: A sample is produced only when its own frame start and the frame start after it are exactly 14 bits apart. The first frame start after reset, or after a misalignment, produces no sample.
- R6: A frame start that is a distance other than 14 bits from the previous one sets `misalign_o`. The sample ending at that frame start is discarded, and the bad frame start becomes the new reference.
- R7: `misalign_o` stays set until a cycle in which `misalign_clr_i` is high. If a new misalignment is found in the same cycle as a clear, the flag stays set.
- R8: While `rst_n` is low, `sample_o`, `sample_valid_o` and `misalign_o` are zero after the next clock edge.
- R9: A ramp sent on the lane comes out as consecutive codes, with no skipped or repeated values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock (one data pair per cycle) |
| rst_n | input | 1 | Active-low synchronous reset |
| data_rise_i | input | 1 | Data bit captured on the rising edge (earlier bit) |
| data_fall_i | input | 1 | Data bit captured on the falling edge (later bit) |
| frame_rise_i | input | 1 | Frame-clock bit captured on the rising edge |
| frame_fall_i | input | 1 | Frame-clock bit captured on the falling edge |
| misalign_clr_i | input | 1 | Clears the misalignment flag |
| sample_o | output | 14 | Last complete sample |
| sample_valid_o | output | 1 | One-cycle strobe for a new sample |
| misalign_o | output | 1 | Sticky frame-spacing error flag |

## Verification
Detecting a misaligned frame start and clearing the flag in software can happen in the same cycle. The bench causes this by inserting a three-bit gap between two frame streams. It then drives `misalign_clr_i` high in the exact cycle that carries the pair holding the displaced frame start, which it computes from the bit index it generated. After that edge the flag must still be high. The bench also checks that the sample ending at that frame start never shows up among the valid outputs.

// File: rtl/ddrdes_pkg.sv
package ddrdes_pkg;

  typedef enum logic {
    PH_EARLY = 1'b0,
    PH_LATE  = 1'b1
  } bit_phase_e;

  // Distance in serial bits between two frame starts, from the cycle gap
  // and the half-cycle position of each start.
  function automatic int frame_bit_gap(int cyc_gap, logic ph_now, logic ph_prev);
    int a;
    int b;
    a = ph_now  ? 1 : 0;
    b = ph_prev ? 1 : 0;
    return 2 * cyc_gap + a - b;
  endfunction

endpackage

// File: rtl/ddrdes_edge.sv
module ddrdes_edge
  import ddrdes_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_rise_i,
  input  logic       frame_fall_i,
  output logic       start_o,
  output bit_phase_e phase_o
);

  logic frame_last_q;
  logic start_early;
  logic start_late;

  always_ff @(posedge clk) begin
    if (!rst_n) frame_last_q <= 1'b1;
    else        frame_last_q <= frame_fall_i;
  end

  assign start_early = !frame_last_q && frame_rise_i;
  assign start_late  = !frame_rise_i && frame_fall_i;
  assign start_o     = start_early || start_late;
  assign phase_o     = start_late ? PH_LATE : PH_EARLY;

endmodule

// File: rtl/ddrdes_shift.sv
module ddrdes_shift
  import ddrdes_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                data_rise_i,
  input  logic                data_fall_i,
  input  bit_phase_e          phase_i,
  output logic [SAMPLE_W-1:0] window_o
);

  logic [SAMPLE_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[SAMPLE_W-3:0], data_rise_i, data_fall_i};
  end

  // Early start: the sample ended on the previous falling bit.
  // Late start: the sample ended on this cycle's rising bit.
  always_comb begin
    if (phase_i == PH_LATE) window_o = {sr_q[SAMPLE_W-2:0], data_rise_i};
    else                    window_o = sr_q;
  end

endmodule

// File: rtl/ddrdes_track.sv
module ddrdes_track
  import ddrdes_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  bit_phase_e phase_i,
  input  logic       clr_i,
  output logic       take_o,
  output logic       set_o,
  output logic       misalign_o
);

  localparam int CYC_MAX = SAMPLE_W / 2 + 1;
  localparam int CNT_W   = $clog2(CYC_MAX + 1);

  logic [CNT_W-1:0] cyc_q;
  logic             armed_q;
  bit_phase_e       ph_prev_q;
  logic             flag_q;
  logic             spacing_ok;

  assign spacing_ok = frame_bit_gap(int'(cyc_q), phase_i, ph_prev_q) == SAMPLE_W;
  assign take_o     = start_i && armed_q && spacing_ok;
  assign set_o      = start_i && armed_q && !spacing_ok;
  assign misalign_o = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q     <= '0;
      armed_q   <= 1'b0;
      ph_prev_q <= PH_EARLY;
      flag_q    <= 1'b0;
    end else begin
      if (start_i) begin
        cyc_q     <= CNT_W'(1);
        armed_q   <= 1'b1;
        ph_prev_q <= phase_i;
      end else if (int'(cyc_q) < CYC_MAX) begin
        cyc_q <= cyc_q + CNT_W'(1);
      end
      if (set_o)      flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/ddrdes_top.sv
module ddrdes_top
  import ddrdes_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                data_rise_i,
  input  logic                data_fall_i,
  input  logic                frame_rise_i,
  input  logic                frame_fall_i,
  input  logic                misalign_clr_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_valid_o,
  output logic                misalign_o
);

  logic                frame_start;
  bit_phase_e          start_phase;
  logic [SAMPLE_W-1:0] window;
  logic                take_w;
  logic                set_w;
  logic [SAMPLE_W-1:0] sample_q;
  logic                valid_q;

  ddrdes_edge u_edge (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_rise_i (frame_rise_i),
    .frame_fall_i (frame_fall_i),
    .start_o      (frame_start),
    .phase_o      (start_phase)
  );

  ddrdes_shift #(.SAMPLE_W(SAMPLE_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_rise_i (data_rise_i),
    .data_fall_i (data_fall_i),
    .phase_i     (start_phase),
    .window_o    (window)
  );

  ddrdes_track #(.SAMPLE_W(SAMPLE_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (frame_start),
    .phase_i    (start_phase),
    .clr_i      (misalign_clr_i),
    .take_o     (take_w),
    .set_o      (set_w),
    .misalign_o (misalign_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= take_w;
      if (take_w) sample_q <= window;
    end
  end

  assign sample_o       = sample_q;
  assign sample_valid_o = valid_q;

endmodule

// File: rtl/ddrdes_chk.sv
module ddrdes_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_start,
  input logic take_w,
  input logic set_w,
  input logic misalign_clr_i,
  input logic sample_valid_o,
  input logic misalign_o
);

  AST_TAKE_XOR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_w && set_w)); // R6

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid_o |=> !sample_valid_o); // R4

  AST_VALID_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_valid_o) |-> $past(frame_start)); // R5

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (misalign_o && !misalign_clr_i) |=> misalign_o); // R7

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (misalign_clr_i && !set_w) |=> !misalign_o); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_w |=> misalign_o); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!sample_valid_o && !misalign_o)); // R8

endmodule

bind ddrdes_top ddrdes_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .frame_start    (frame_start),
  .take_w         (take_w),
  .set_w          (set_w),
  .misalign_clr_i (misalign_clr_i),
  .sample_valid_o (sample_valid_o),
  .misalign_o     (misalign_o)
);

// File: tb/tb_ddrdes_top.sv
`timescale 1ns/1ps
module tb_ddrdes_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        d_r = 1'b0, d_f = 1'b0, f_r = 1'b0, f_f = 1'b0, clr = 1'b0;
  logic [13:0] sample;
  logic        valid, misalign;

  int checks = 0;
  int fails = 0;

  logic        dbits [0:4095];
  logic        fbits [0:4095];
  int          wi = 0;
  logic [13:0] expq [0:255];
  int          ne = 0;
  int          rd = 0;
  logic [13:0] obs [0:255];
  int          first_pair = -1;

  always #2.5 clk = ~clk;

  ddrdes_top dut (
    .clk(clk), .rst_n(rst_n), .data_rise_i(d_r), .data_fall_i(d_f),
    .frame_rise_i(f_r), .frame_fall_i(f_f), .misalign_clr_i(clr),
    .sample_o(sample), .sample_valid_o(valid), .misalign_o(misalign));

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic add_bit(logic d, logic f);
    dbits[wi] = d; fbits[wi] = f; wi++;
  endtask

  task automatic add_pad(int n);
    for (int i = 0; i < n; i++) add_bit(1'b0, 1'b0);
  endtask

  // MSB first, frame high for the first half of the sample
  task automatic add_sample(logic [13:0] v);
    for (int i = 0; i < 14; i++) add_bit(v[13-i], i < 7);
    expq[ne] = v; ne++;
  endtask

  task automatic close_stream();
    add_bit(1'b0, 1'b1);
    add_pad(2);
    if (wi % 2 != 0) add_pad(1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; d_r = 0; d_f = 0; f_r = 0; f_f = 0; clr = 0;
    @(posedge clk); @(posedge clk); #1;
    chk(valid == 1'b0 && misalign == 1'b0 && sample == '0, "R8 reset",
        {valid, misalign, sample}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    wi = 0; ne = 0; rd = 0; first_pair = -1;
  endtask

  task automatic send(int clr_pair);
    logic prev_v;
    prev_v = 1'b0;
    for (int p = 0; p < wi / 2; p++) begin
      @(negedge clk);
      d_r = dbits[2*p]; d_f = dbits[2*p+1];
      f_r = fbits[2*p]; f_f = fbits[2*p+1];
      clr = (p == clr_pair);
      @(posedge clk); #1;
      if (valid) begin
        if (first_pair < 0) first_pair = p;
        if (rd < ne) begin
          chk(sample == expq[rd], "R1 sample value", sample, expq[rd]);
          obs[rd] = sample;
        end
        rd++;
      end
      if (prev_v && valid) chk(1'b0, "R4 back-to-back valid", 1, 0);
      prev_v = valid;
    end
    @(negedge clk);
    d_r = 0; d_f = 0; f_r = 0; f_f = 0; clr = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      d_r = 0; d_f = 0; f_r = 0; f_f = 0; clr = 0;
    end
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int pre;
    int cp;
    logic [13:0] base;
    void'($urandom(32'h5eed_1234));

    // R2: frame start on the rising-edge bit
    do_reset();
    add_pad(2);
    for (int i = 0; i < 4; i++) add_sample(14'h3F80);
    close_stream();
    send(-1);
    chk(rd == ne, "R5 sample count early", rd, ne);
    chk(first_pair == (2 + 14) / 2, "R4 first valid cycle", first_pair, 8);
    chk(obs[0] == 14'h3F80, "R2 unrotated pattern", obs[0], 14'h3F80);

    // R3: frame start on the falling-edge bit
    do_reset();
    add_pad(3);
    add_sample(14'h3F80); add_sample(14'h0001);
    add_sample(14'h2000); add_sample(14'h1555);
    close_stream();
    send(-1);
    chk(rd == ne, "R5 sample count late", rd, ne);
    chk(first_pair == (3 + 14) / 2, "R4 first valid cycle late", first_pair, 8);
    chk(obs[1] == 14'h0001 && obs[2] == 14'h2000, "R3 unrotated late",
        obs[1], 14'h0001);

    // R9: ramp with random phase
    do_reset();
    pre = 1 + int'($urandom % 6);
    base = 14'($urandom);
    add_pad(pre);
    for (int i = 0; i < 20; i++) add_sample(base + 14'(i));
    close_stream();
    send(-1);
    chk(rd == 20, "R9 ramp count", rd, 20);
    for (int i = 1; i < 20; i++)
      chk(obs[i] == obs[i-1] + 14'd1, "R9 ramp step", obs[i], obs[i-1] + 14'd1);

    // R1: random samples, random phase
    do_reset();
    pre = 1 + int'($urandom % 7);
    add_pad(pre);
    for (int i = 0; i < 30; i++) add_sample(14'($urandom));
    close_stream();
    send(-1);
    chk(rd == ne, "R1 random count", rd, ne);
    chk(misalign == 1'b0, "R6 no flag on clean stream", misalign, 0);

    // R6/R7: gap of 3 bits, clear driven in the cycle of the bad start
    do_reset();
    add_pad(2);
    for (int i = 0; i < 5; i++) add_sample(14'($urandom));
    ne--;                         // sample ending at the bad start is dropped
    add_pad(3);
    cp = wi / 2;
    for (int i = 0; i < 4; i++) add_sample(14'($urandom));
    close_stream();
    send(cp);
    chk(rd == ne, "R6 dropped sample", rd, ne);
    chk(misalign == 1'b1, "R7 set wins over clear", misalign, 1);
    idle(10);
    @(posedge clk); #1;
    chk(misalign == 1'b1, "R7 sticky", misalign, 1);
    @(negedge clk); clr = 1'b1;
    @(posedge clk); #1;
    chk(misalign == 1'b0, "R7 clear", misalign, 0);
    @(negedge clk); clr = 1'b0;

    // R8: reset clears a set flag
    wi = 0; ne = 0; rd = 0;
    add_pad(2);
    for (int i = 0; i < 2; i++) add_sample(14'h0AAA);
    add_pad(5);
    add_sample(14'h0AAA);
    close_stream();
    send(-1);
    chk(misalign == 1'b1, "R6 flag after odd gap", misalign, 1);
    do_reset();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule